// File: doc/BRIEF.md
# Load/Store Data Formatter

This combinational block sits between a 32-bit core and a data memory that is one word wide. A 3-bit width code gives both the access size and, for loads, whether the narrow value is sign- or zero-extended. The block reduces that code to an internal 2-bit size class (1x byte, 01 halfword, 00 word) and a signedness bit. It uses the two low address bits to pick byte lanes. Byte lane k holds bits 8k+7:8k, so lane 0 is the least significant byte.

On a store, the block copies the narrow data into every lane of the write word and raises byte enables only for the lanes being addressed. On a load, it takes the addressed byte or halfword from the word the memory returns and extends it to 32 bits. An access that does not fit its natural boundary raises a flag and writes no lanes. When neither strobe is active, no lane is enabled.

Top module: `ls_data_formatter`

## Requirements
- R1: Width code 000 on a load returns the byte in lane addr_lo, with bit 7 of that byte copied into bits 31:8.
- R2: Width code 100 on a load returns the byte in lane addr_lo, with bits 31:8 zero.
- R3: Width code 001 on a load returns the halfword made of lanes 2*addr_lo[1] and 2*addr_lo[1]+1, with its bit 15 copied into bits 31:16.
- R4: Width code 101 on a load returns the same halfword as R3, with bits 31:16 zero.
- R5: Width codes 010, 011, 110 and 111 are word accesses: load_data equals mem_rdata, and the address does not select a lane.
- R6: mem_wdata carries store_data[7:0] in all four lanes for byte codes, store_data[15:0] in both halves for halfword codes, and store_data unchanged for word codes.
- R7: With a strobe active and the access aligned, byte_en is 1<<addr_lo for a byte, 4'b0011 or 4'b1100 (addr_lo[1] = 0 or 1) for a halfword, and 4'b1111 for a word.
- R8: With a strobe active, a halfword with addr_lo[0]=1 or a word with addr_lo not 00 sets misaligned to 1 and byte_en to 4'b0000. Every other case leaves misaligned at 0.
- R9: With rd_en and wr_en both low, byte_en is 4'b0000 and misaligned is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_lo | input | 2 | Low address bits of the access |
| width_code | input | 3 | Access size and extension code |
| rd_en | input | 1 | Load strobe |
| wr_en | input | 1 | Store strobe |
| store_data | input | 32 | Data from the core to be stored |
| mem_rdata | input | 32 | Word returned by the memory |
| mem_wdata | output | 32 | Lane-replicated write data |
| byte_en | output | 4 | Per-lane write/access enables |
| load_data | output | 32 | Extended load result |
| misaligned | output | 1 | Access crosses its natural boundary |

## Verification
The block holds no state, so any fault in the size reduction or lane selection appears on the ports during the same cycle the inputs change. A wrong size class shows up as a byte_en population count that does not match the code. A wrong signedness bit shows up as upper load bits that do not follow the selected sign bit. A lane that is off by one shows up as the wrong byte in load_data. The sweep covers every width code, every address, every strobe pair and several data patterns with sign bits set and clear, so each of these faults is reported at its first occurrence.

// File: rtl/lsfmt_pkg.sv
package lsfmt_pkg;

  localparam int unsigned LSF_DATA_W = 32;
  localparam int unsigned LSF_LANES  = LSF_DATA_W / 8;
  localparam int unsigned LSF_AW     = $clog2(LSF_LANES);

  // Internal size class: 1x byte, 01 halfword, 00 word
  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_BYTE = 2'b10;

  // Reduce the 3-bit width code to a size class; unused codes act as word
  function automatic logic [1:0] reduce_width(input logic [2:0] wc);
    case (wc[1:0])
      2'b00:   return SZ_BYTE;
      2'b01:   return SZ_HALF;
      default: return SZ_WORD;
    endcase
  endfunction

  function automatic logic size_is_byte(input logic [1:0] sz);
    return sz[1];
  endfunction

  function automatic logic size_is_half(input logic [1:0] sz);
    return (sz == SZ_HALF);
  endfunction

  // Lanes touched by an access of class sz at address a
  function automatic logic [LSF_LANES-1:0] lane_mask(input logic [1:0] sz,
                                                      input logic [LSF_AW-1:0] a);
    logic [LSF_LANES-1:0] one;
    logic [LSF_LANES-1:0] pair;
    logic [LSF_AW-1:0]    half_base;
    one       = {{(LSF_LANES-1){1'b0}}, 1'b1};
    pair      = {{(LSF_LANES-2){1'b0}}, 2'b11};
    half_base = {a[LSF_AW-1:1], 1'b0};
    if (size_is_byte(sz))      return one << a;
    else if (size_is_half(sz)) return pair << half_base;
    else                       return {LSF_LANES{1'b1}};
  endfunction

  // True when the access does not sit on its natural boundary
  function automatic logic off_boundary(input logic [1:0] sz,
                                        input logic [LSF_AW-1:0] a);
    if (size_is_byte(sz))      return 1'b0;
    else if (size_is_half(sz)) return a[0];
    else                       return (a != '0);
  endfunction

  // Pick the addressed byte and extend it
  function automatic logic [LSF_DATA_W-1:0] take_byte(input logic [LSF_DATA_W-1:0] w,
                                                      input logic [LSF_AW-1:0] a,
                                                      input logic sgn);
    logic [LSF_DATA_W-1:0] sh;
    sh = w >> {a, 3'b000};
    return {{(LSF_DATA_W-8){sgn & sh[7]}}, sh[7:0]};
  endfunction

  // Pick the addressed halfword and extend it
  function automatic logic [LSF_DATA_W-1:0] take_half(input logic [LSF_DATA_W-1:0] w,
                                                      input logic [LSF_AW-1:0] a,
                                                      input logic sgn);
    logic [LSF_DATA_W-1:0] sh;
    sh = w >> {a[LSF_AW-1:1], 4'b0000};
    return {{(LSF_DATA_W-16){sgn & sh[15]}}, sh[15:0]};
  endfunction

endpackage

// File: rtl/lsfmt_decode.sv
module lsfmt_decode
  import lsfmt_pkg::*;
#(
  parameter int unsigned AW = LSF_AW
) (
  input  logic [2:0]    width_code,
  input  logic [AW-1:0] addr_lo,
  input  logic          rd_en,
  input  logic          wr_en,
  output logic [1:0]    size_code,
  output logic          is_signed,
  output logic          access,
  output logic          misaligned
);

  logic bad_boundary;

  always_comb begin
    size_code    = reduce_width(width_code);
    is_signed    = ~width_code[2];
    access       = rd_en | wr_en;
    bad_boundary = off_boundary(size_code, addr_lo);
    misaligned   = access & bad_boundary;
  end

endmodule

// File: rtl/lsfmt_store.sv
module lsfmt_store
  import lsfmt_pkg::*;
#(
  parameter int unsigned DATA_W = LSF_DATA_W,
  parameter int unsigned LANES  = DATA_W / 8,
  parameter int unsigned AW     = $clog2(LANES)
) (
  input  logic [1:0]        size_code,
  input  logic [AW-1:0]     addr_lo,
  input  logic              access,
  input  logic              misaligned,
  input  logic [DATA_W-1:0] store_data,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [LANES-1:0]  byte_en,
  output logic [LANES-1:0]  raw_mask
);

  logic sel_byte;
  logic sel_half;

  assign sel_byte = size_is_byte(size_code);
  assign sel_half = size_is_half(size_code);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int unsigned HK = k % 2;
    always_comb begin
      if (sel_byte)      mem_wdata[8*k +: 8] = store_data[7:0];
      else if (sel_half) mem_wdata[8*k +: 8] = store_data[8*HK +: 8];
      else               mem_wdata[8*k +: 8] = store_data[8*k +: 8];
    end
  end

  assign raw_mask = lane_mask(size_code, addr_lo);
  assign byte_en  = (access && !misaligned) ? raw_mask : '0;

endmodule

// File: rtl/lsfmt_load.sv
module lsfmt_load
  import lsfmt_pkg::*;
#(
  parameter int unsigned DATA_W = LSF_DATA_W,
  parameter int unsigned AW     = LSF_AW
) (
  input  logic [1:0]        size_code,
  input  logic              is_signed,
  input  logic [AW-1:0]     addr_lo,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] load_data
);

  logic [DATA_W-1:0] byte_val;
  logic [DATA_W-1:0] half_val;

  assign byte_val = take_byte(mem_rdata, addr_lo, is_signed);
  assign half_val = take_half(mem_rdata, addr_lo, is_signed);

  always_comb begin
    if (size_is_byte(size_code))      load_data = byte_val;
    else if (size_is_half(size_code)) load_data = half_val;
    else                              load_data = mem_rdata;
  end

endmodule

// File: rtl/ls_data_formatter.sv
module ls_data_formatter
  import lsfmt_pkg::*;
#(
  parameter int unsigned DATA_W = LSF_DATA_W
) (
  input  logic [1:0]        addr_lo,
  input  logic [2:0]        width_code,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] store_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [3:0]        byte_en,
  output logic [DATA_W-1:0] load_data,
  output logic              misaligned
);

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned AW    = $clog2(LANES);

  // Named internal events, visible to the bound checker
  logic [1:0]       size_code;
  logic             is_signed;
  logic             access;
  logic [LANES-1:0] raw_mask;

  lsfmt_decode #(.AW(AW)) decode_i (
    .width_code (width_code),
    .addr_lo    (addr_lo),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .size_code  (size_code),
    .is_signed  (is_signed),
    .access     (access),
    .misaligned (misaligned)
  );

  lsfmt_store #(.DATA_W(DATA_W), .LANES(LANES), .AW(AW)) store_i (
    .size_code  (size_code),
    .addr_lo    (addr_lo),
    .access     (access),
    .misaligned (misaligned),
    .store_data (store_data),
    .mem_wdata  (mem_wdata),
    .byte_en    (byte_en),
    .raw_mask   (raw_mask)
  );

  lsfmt_load #(.DATA_W(DATA_W), .AW(AW)) load_i (
    .size_code  (size_code),
    .is_signed  (is_signed),
    .addr_lo    (addr_lo),
    .mem_rdata  (mem_rdata),
    .load_data  (load_data)
  );

endmodule

// File: rtl/ls_data_formatter_chk.sv
module ls_data_formatter_chk (
  input logic [1:0]  addr_lo,
  input logic [2:0]  width_code,
  input logic        rd_en,
  input logic        wr_en,
  input logic [1:0]  size_code,
  input logic        is_signed,
  input logic [3:0]  raw_mask,
  input logic [31:0] mem_wdata,
  input logic [31:0] mem_rdata,
  input logic [3:0]  byte_en,
  input logic [31:0] load_data,
  input logic        misaligned
);

  always_comb begin
    // R9
    idle_no_enable_chk: assert (rd_en || wr_en || (byte_en == 4'b0000 && !misaligned));
    // R8
    misaligned_blocks_chk: assert (!misaligned || byte_en == 4'b0000);
    // R7
    enable_count_chk: assert (byte_en == 4'b0000 ||
      $countones(byte_en) == (size_code[1] ? 1 : (size_code == 2'b01 ? 2 : 4)));
    // R7
    enable_within_mask_chk: assert ((byte_en & ~raw_mask) == 4'b0000);
    // R6
    byte_replica_chk: assert (!size_code[1] ||
      (mem_wdata[31:24] == mem_wdata[7:0] && mem_wdata[15:8] == mem_wdata[23:16]));
    // R1
    byte_sign_chk: assert (!(size_code[1] && is_signed) ||
      load_data[31:8] == {24{load_data[7]}});
    // R2
    byte_zero_chk: assert (!(size_code[1] && !is_signed) || load_data[31:8] == 24'h0);
    // R4
    half_zero_chk: assert (!(size_code == 2'b01 && !is_signed) || load_data[31:16] == 16'h0);
    // R5
    word_pass_chk: assert (size_code != 2'b00 || load_data == mem_rdata);
    // R5
    width_class_chk: assert (width_code[1:0] != 2'b00 || size_code[1]);
    // R8
    flag_addr_chk: assert (!misaligned || addr_lo != 2'b00);
  end

endmodule

bind ls_data_formatter ls_data_formatter_chk chk_i (
  .addr_lo    (addr_lo),
  .width_code (width_code),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .size_code  (size_code),
  .is_signed  (is_signed),
  .raw_mask   (raw_mask),
  .mem_wdata  (mem_wdata),
  .mem_rdata  (mem_rdata),
  .byte_en    (byte_en),
  .load_data  (load_data),
  .misaligned (misaligned)
);

// File: tb/ls_data_formatter_tb_top.sv
`timescale 1ns/1ps
module ls_data_formatter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr_lo = '0;
  logic [2:0]  width_code = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] store_data = '0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem_wdata;
  logic [3:0]  byte_en;
  logic [31:0] load_data;
  logic        misaligned;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ls_data_formatter dut_i (
    .addr_lo    (addr_lo),
    .width_code (width_code),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .store_data (store_data),
    .mem_rdata  (mem_rdata),
    .mem_wdata  (mem_wdata),
    .byte_en    (byte_en),
    .load_data  (load_data),
    .misaligned (misaligned)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (wc=%b a=%0d rd=%b wr=%b)",
               req, got, exp, width_code, addr_lo, rd_en, wr_en);
    end
  endtask

  function automatic logic [31:0] pattern(input int i);
    case (i)
      0: return 32'h80FF_7F01;
      1: return 32'h7F80_01FE;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0000;
      4: return 32'h1234_8765;
      default: return 32'hA5C3_3C5A;
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: idle state after start
    check("R9 idle byte_en", {28'h0, byte_en}, 32'h0);
    check("R9 idle misaligned", {31'h0, misaligned}, 32'h0);

    for (int p = 0; p < 6; p++) begin
      for (int wc = 0; wc < 8; wc++) begin
        for (int a = 0; a < 4; a++) begin
          for (int s = 0; s < 4; s++) begin
            logic [31:0] e_load, e_wdata, sh;
            logic [3:0]  e_be;
            logic        e_mis, is_b, is_h, sgn, act;
            string       lreq;
            @(posedge clk);
            width_code = wc[2:0];
            addr_lo    = a[1:0];
            rd_en      = s[0];
            wr_en      = s[1];
            mem_rdata  = pattern(p);
            store_data = pattern(p) ^ 32'h5A5A_5A5A;
            is_b = (wc % 4) == 0;
            is_h = (wc % 4) == 1;
            sgn  = wc < 4;
            act  = (s != 0);
            if (is_b) begin
              sh = (mem_rdata >> (8 * a)) & 32'hFF;
              if (sgn && sh[7]) sh = sh | 32'hFFFF_FF00;
              e_load  = sh;
              e_wdata = {4{store_data[7:0]}};
              e_mis   = 1'b0;
              e_be    = 4'(1 << a);
              lreq    = sgn ? "R1 load" : "R2 load";
            end else if (is_h) begin
              sh = (mem_rdata >> (16 * (a / 2))) & 32'hFFFF;
              if (sgn && sh[15]) sh = sh | 32'hFFFF_0000;
              e_load  = sh;
              e_wdata = {2{store_data[15:0]}};
              e_mis   = act && (a % 2 == 1);
              e_be    = (a >= 2) ? 4'b1100 : 4'b0011;
              lreq    = sgn ? "R3 load" : "R4 load";
            end else begin
              e_load  = mem_rdata;
              e_wdata = store_data;
              e_mis   = act && (a != 0);
              e_be    = 4'b1111;
              lreq    = "R5 load";
            end
            if (!act || e_mis) e_be = 4'b0000;
            @(negedge clk);
            check(lreq, load_data, e_load);
            check("R6 wdata", mem_wdata, e_wdata);
            check(act ? (e_mis ? "R8 byte_en" : "R7 byte_en") : "R9 byte_en",
                  {28'h0, byte_en}, {28'h0, e_be});
            check(act ? "R8 misaligned" : "R9 misaligned",
                  {31'h0, misaligned}, {31'h0, e_mis});
          end
        end
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule